// File: doc/BRIEF.md
# Timer DMA Pointer Arbiter

This block sits beside a capture/compare timer and runs its two DMA channels. The capture channel moves each captured value out to memory or the register file. The compare channel brings a new compare value in from memory or the register file. Each channel is armed by loading a nonzero transfer count. Its timer events are then latched as pending requests. One channel at a time is granted, and the capture channel wins when both wait. The grant is held until the bus logic reports that the transfer has completed.

While a channel is granted, the block drives the register-file byte addresses of that channel's counter pointer and address pointer. Both are formed from six shared base bits. In split mode the two channels keep separate counter and address pointers, and address bit 1 tells them apart. In register-to-register mode both channels use one adjacent counter/address pair built from the counter base alone. Each completed transfer decrements the channel's counter. The transfer that brings the counter to zero raises an end-of-block strobe and disarms the channel. The bus transfer itself is handled elsewhere.

Top module: `tdma_ptr_arb`

## Requirements
- R1: After reset, `gnt`, `eob`, `eob_irq`, `cnt_ptr` and `addr_ptr` are all zero, and both channels are disarmed.
- R2: Channel index 0 is capture and index 1 is compare. This holds for every 2-bit port. A pulse on `evt_req[i]` is latched as pending only if `req_en[i]` is 1 and channel i is armed. Otherwise it is dropped, and raising `req_en[i]` later does not bring it back.
- R3: If both channels have a pending request while no grant is active, capture is granted first (`gnt`=01). Compare (`gnt`=10) follows after capture's transfer completes.
- R4: At most one bit of `gnt` is set. A grant stays unchanged until `xfer_done` is sampled high. A request that arrives during a grant stays pending and is granted after that transfer.
- R5: When no grant is active, a request sampled on rising edge k produces `gnt` after edge k+1. A `xfer_done` sampled on an edge drops `gnt` after that same edge.
- R6: With `reg_mode`=0 and channel c granted, `cnt_ptr` = 4*`cnt_base` + 2*c and `addr_ptr` = 4*`addr_base` + 2*c.
- R7: With `reg_mode`=1, either granted channel gets `cnt_ptr` = 4*`cnt_base` and `addr_ptr` = 4*`cnt_base` + 2. `addr_base` has no effect on either output.
- R8: Each pointer output addresses the high byte of a 16-bit pointer and is always even. The low byte sits at that address + 1. Both outputs are zero when no grant is active.
- R9: A cycle with `ld_valid` high writes `ld_count` into the counter of channel `ld_chan`. A nonzero value arms the channel and zero disarms it.
- R10: Each completed transfer decrements the granted channel's counter. When a counter of 1 completes, `eob[c]` is high for exactly the one cycle after that edge. The channel is then disarmed and ignores further requests.
- R11: `eob_irq[c]` is high exactly when `eob[c]` is high and `eob_ie[c]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_req | input | 2 | Timer event requests (0 capture, 1 compare) |
| req_en | input | 2 | Per-channel request enable |
| eob_ie | input | 2 | Per-channel end-of-block interrupt enable |
| ld_valid | input | 1 | Counter load strobe |
| ld_chan | input | 1 | Channel selected for load |
| ld_count | input | 16 | Transfer count to load |
| cnt_base | input | 6 | Shared counter-pointer base bits |
| addr_base | input | 6 | Shared address-pointer base bits |
| reg_mode | input | 1 | 1 selects register-to-register pointer layout |
| xfer_done | input | 1 | Current granted transfer has completed |
| gnt | output | 2 | One-hot grant |
| cnt_ptr | output | 8 | Counter pointer high-byte address |
| addr_ptr | output | 8 | Address pointer high-byte address |
| eob | output | 2 | End-of-block strobe |
| eob_irq | output | 2 | End-of-block interrupt request |

## Verification
The assertions take several things for granted about the inputs. A counter is never reloaded while its channel holds the grant, which keeps a granted counter nonzero until its final transfer. `xfer_done` is treated as meaningful only during a grant. The bench follows these rules by loading counters and changing the mode or base bits only while `gnt` is zero. It pulses `xfer_done` only after it has seen a grant. It drives every request as a single-cycle pulse at the falling edge, so that each pending, grant and end-of-block transition can be checked in the exact cycle the requirements name.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
    localparam int NCH    = 2;
    localparam int BASE_W = 6;
    localparam int PTR_W  = BASE_W + 2;

    typedef enum logic {CH_CAPT = 1'b0, CH_CMP = 1'b1} chan_e;

    typedef struct packed {
        logic [PTR_W-1:0] cnt;
        logic [PTR_W-1:0] addr;
    } ptr_pair_t;

    // split layout: per-channel pointers, bit 1 selects the channel
    function automatic ptr_pair_t split_ptrs(input logic [BASE_W-1:0] cb,
                                             input logic [BASE_W-1:0] ab,
                                             input chan_e ch);
        ptr_pair_t p;
        p.cnt  = {cb, ch, 1'b0};
        p.addr = {ab, ch, 1'b0};
        return p;
    endfunction

    // register-to-register layout: one adjacent pair from the counter base
    function automatic ptr_pair_t joint_ptrs(input logic [BASE_W-1:0] cb);
        ptr_pair_t p;
        p.cnt  = {cb, 2'b00};
        p.addr = {cb, 2'b10};
        return p;
    endfunction
endpackage

// File: rtl/tdma_chan_ctr.sv
module tdma_chan_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_val_i,
    input  logic             dec_i,
    output logic             armed_o,
    output logic             eob_o
);
    logic [CNT_W-1:0] count_q;
    logic             eob_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            eob_q   <= 1'b0;
        end else begin
            eob_q <= dec_i && (count_q == CNT_W'(1));
            if (ld_i)
                count_q <= ld_val_i;
            else if (dec_i && count_q != '0)
                count_q <= count_q - CNT_W'(1);
        end
    end

    assign armed_o = (count_q != '0);
    assign eob_o   = eob_q;

    AST_DEC_ARMED: assert property (@(posedge clk) disable iff (rst)
        dec_i |-> armed_o);                                       // R10
    AST_EOB_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
        eob_o |-> $past(dec_i));                                  // R10
    AST_EOB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (eob_o && !$past(ld_i)) |-> !armed_o);                    // R10
endmodule

// File: rtl/tdma_arbiter.sv
module tdma_arbiter
    import tdma_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] evt_req_i,
    input  logic [NCH-1:0] req_en_i,
    input  logic [NCH-1:0] armed_i,
    input  logic           done_i,
    output logic [NCH-1:0] gnt_o,
    output logic [NCH-1:0] dec_o
);
    logic [NCH-1:0] pend_q, gnt_q, qual, set, clr, win;
    logic           busy_q;

    assign set  = evt_req_i & req_en_i & armed_i;
    assign qual = pend_q & req_en_i & armed_i;
    // fixed priority: capture (index 0) above compare
    assign win  = qual[CH_CAPT] ? NCH'(1) << CH_CAPT :
                  qual[CH_CMP]  ? NCH'(1) << CH_CMP  : '0;
    assign clr  = busy_q ? '0 : win;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            gnt_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            pend_q <= ((pend_q & ~clr) | set) & armed_i;
            if (!busy_q) begin
                if (win != '0) begin
                    busy_q <= 1'b1;
                    gnt_q  <= win;
                end
            end else if (done_i) begin
                busy_q <= 1'b0;
                gnt_q  <= '0;
            end
        end
    end

    assign gnt_o = gnt_q;
    assign dec_o = gnt_q & {NCH{done_i}};

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o));                                         // R4
    AST_CAPT_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && qual == 2'b11) |=> gnt_o == 2'b01);           // R3
    AST_GNT_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !done_i) |=> $stable(gnt_o));                  // R4
    AST_DONE_DROPS: assert property (@(posedge clk) disable iff (rst)
        (busy_q && done_i) |=> gnt_o == '0);                      // R5
endmodule

// File: rtl/tdma_ptr_gen.sv
module tdma_ptr_gen
    import tdma_pkg::*;
(
    input  logic [NCH-1:0]    gnt_i,
    input  logic              reg_mode_i,
    input  logic [BASE_W-1:0] cnt_base_i,
    input  logic [BASE_W-1:0] addr_base_i,
    output logic [PTR_W-1:0]  cnt_ptr_o,
    output logic [PTR_W-1:0]  addr_ptr_o
);
    ptr_pair_t p;
    chan_e     ch;

    always_comb begin
        ch = gnt_i[CH_CMP] ? CH_CMP : CH_CAPT;
        if (gnt_i == '0)
            p = '0;
        else if (reg_mode_i)
            p = joint_ptrs(cnt_base_i);
        else
            p = split_ptrs(cnt_base_i, addr_base_i, ch);
    end

    assign cnt_ptr_o  = p.cnt;
    assign addr_ptr_o = p.addr;
endmodule

// File: rtl/tdma_ptr_arb.sv
module tdma_ptr_arb
    import tdma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    evt_req,
    input  logic [NCH-1:0]    req_en,
    input  logic [NCH-1:0]    eob_ie,
    input  logic              ld_valid,
    input  logic              ld_chan,
    input  logic [CNT_W-1:0]  ld_count,
    input  logic [BASE_W-1:0] cnt_base,
    input  logic [BASE_W-1:0] addr_base,
    input  logic              reg_mode,
    input  logic              xfer_done,
    output logic [NCH-1:0]    gnt,
    output logic [PTR_W-1:0]  cnt_ptr,
    output logic [PTR_W-1:0]  addr_ptr,
    output logic [NCH-1:0]    eob,
    output logic [NCH-1:0]    eob_irq
);
    logic [NCH-1:0] armed, dec;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tdma_chan_ctr #(.CNT_W(CNT_W)) i_ctr (
            .clk      (clk),
            .rst      (rst),
            .ld_i     (ld_valid && (ld_chan == 1'(c))),
            .ld_val_i (ld_count),
            .dec_i    (dec[c]),
            .armed_o  (armed[c]),
            .eob_o    (eob[c])
        );
    end

    tdma_arbiter i_arb (
        .clk       (clk),
        .rst       (rst),
        .evt_req_i (evt_req),
        .req_en_i  (req_en),
        .armed_i   (armed),
        .done_i    (xfer_done),
        .gnt_o     (gnt),
        .dec_o     (dec)
    );

    tdma_ptr_gen i_ptr (
        .gnt_i       (gnt),
        .reg_mode_i  (reg_mode),
        .cnt_base_i  (cnt_base),
        .addr_base_i (addr_base),
        .cnt_ptr_o   (cnt_ptr),
        .addr_ptr_o  (addr_ptr)
    );

    assign eob_irq = eob & eob_ie;

    AST_SPLIT_SELECT: assert property (@(posedge clk) disable iff (rst)
        (gnt != '0 && !reg_mode) |->
            (cnt_ptr[1] == gnt[CH_CMP] && addr_ptr[1] == gnt[CH_CMP]));    // R6
    AST_JOINT_PAIR: assert property (@(posedge clk) disable iff (rst)
        (gnt != '0 && reg_mode) |-> addr_ptr == cnt_ptr + PTR_W'(2));     // R7
    AST_HIGH_EVEN: assert property (@(posedge clk) disable iff (rst)
        !cnt_ptr[0] && !addr_ptr[0]);                                      // R8
    AST_IDLE_PTRS: assert property (@(posedge clk) disable iff (rst)
        gnt == '0 |-> (cnt_ptr == '0 && addr_ptr == '0));                  // R8
endmodule

// File: tb/test_tdma_ptr_arb.sv
module test_tdma_ptr_arb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] evt_req = '0, req_en = 2'b11, eob_ie = '0;
    logic       ld_valid = 1'b0, ld_chan = 1'b0;
    logic [15:0] ld_count = '0;
    logic [5:0] cnt_base = '0, addr_base = '0;
    logic       reg_mode = 1'b0, xfer_done = 1'b0;
    logic [1:0] gnt, eob, eob_irq;
    logic [7:0] cnt_ptr, addr_ptr;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    tdma_ptr_arb i_tdma_ptr_arb (
        .clk(clk), .rst(rst), .evt_req(evt_req), .req_en(req_en), .eob_ie(eob_ie),
        .ld_valid(ld_valid), .ld_chan(ld_chan), .ld_count(ld_count),
        .cnt_base(cnt_base), .addr_base(addr_base), .reg_mode(reg_mode),
        .xfer_done(xfer_done), .gnt(gnt), .cnt_ptr(cnt_ptr), .addr_ptr(addr_ptr),
        .eob(eob), .eob_irq(eob_irq)
    );

    // vector: {mode, chan, cnt_base[5:0], addr_base[5:0]}
    localparam logic [13:0] VEC [8] = '{
        {1'b0, 1'b0, 6'h05, 6'h2a},
        {1'b0, 1'b1, 6'h05, 6'h2a},
        {1'b0, 1'b0, 6'h3f, 6'h00},
        {1'b0, 1'b1, 6'h00, 6'h3f},
        {1'b1, 1'b0, 6'h11, 6'h22},
        {1'b1, 1'b1, 6'h11, 6'h22},
        {1'b1, 1'b1, 6'h11, 6'h07},
        {1'b1, 1'b0, 6'h3c, 6'h15}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic ch, input logic [15:0] n);
        @(negedge clk); ld_valid = 1'b1; ld_chan = ch; ld_count = n;
        @(negedge clk); ld_valid = 1'b0;
    endtask

    // request pulse; returns at the falling edge after the latching edge
    task automatic req_pulse(input logic [1:0] r);
        @(negedge clk); evt_req = r;
        @(negedge clk); evt_req = '0;
    endtask

    task automatic done_pulse();
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL R4 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 gnt", 32'(gnt), 0);
        check("R1 eob", 32'(eob), 0);
        check("R1 eob_irq", 32'(eob_irq), 0);
        check("R1 ptrs", {cnt_ptr, addr_ptr}, 0);
        rst = 1'b0;

        // R2: disarmed channel ignores requests
        req_pulse(2'b01);
        @(negedge clk);
        check("R2 unarmed no grant", 32'(gnt), 0);

        // pointer vectors (R6, R7, R8, R5)
        for (int i = 0; i < 8; i++) begin
            logic       m  = VEC[i][13];
            logic       ch = VEC[i][12];
            logic [5:0] cb = VEC[i][11:6];
            logic [5:0] ab = VEC[i][5:0];
            int ec, ea;
            ec = m ? cb * 4 : cb * 4 + (ch ? 2 : 0);
            ea = m ? cb * 4 + 2 : ab * 4 + (ch ? 2 : 0);
            reg_mode = m; cnt_base = cb; addr_base = ab;
            load(ch, 16'd5);
            req_pulse(ch ? 2'b10 : 2'b01);
            check("R5 no grant yet", 32'(gnt), 0);
            @(negedge clk);
            check("R5 grant", 32'(gnt), ch ? 2 : 1);
            check(m ? "R7 cnt_ptr" : "R6 cnt_ptr", 32'(cnt_ptr), 32'(ec));
            check(m ? "R7 addr_ptr" : "R6 addr_ptr", 32'(addr_ptr), 32'(ea));
            check("R8 high byte even", 32'({cnt_ptr[0], addr_ptr[0]}), 0);
            done_pulse();
            check("R5 grant dropped", 32'(gnt), 0);
            check("R8 idle ptrs", {cnt_ptr, addr_ptr}, 0);
        end
        reg_mode = 1'b0; cnt_base = 6'h08; addr_base = 6'h10;

        // R3: simultaneous requests, capture first
        load(1'b0, 16'd4); load(1'b1, 16'd4);
        req_pulse(2'b11);
        @(negedge clk);
        check("R3 capture first", 32'(gnt), 1);
        done_pulse();
        @(negedge clk);
        check("R3 compare after", 32'(gnt), 2);

        // R4: request during grant stays pending; grant held
        req_pulse(2'b01);
        repeat (3) @(negedge clk);
        check("R4 grant held", 32'(gnt), 2);
        done_pulse();
        @(negedge clk);
        check("R4 pending served", 32'(gnt), 1);
        done_pulse();

        // R2: request while disabled is dropped
        req_en = 2'b10;
        req_pulse(2'b01);
        req_en = 2'b11;
        repeat (2) @(negedge clk);
        check("R2 masked dropped", 32'(gnt), 0);

        // R10/R11: count of 2 on capture, interrupt enabled
        eob_ie = 2'b01;
        load(1'b0, 16'd2);
        req_pulse(2'b01); @(negedge clk);
        check("R10 first grant", 32'(gnt), 1);
        done_pulse();
        check("R10 no eob yet", 32'(eob), 0);
        req_pulse(2'b01); @(negedge clk);
        done_pulse();
        check("R10 eob capture", 32'(eob), 1);
        check("R11 irq enabled", 32'(eob_irq), 1);
        @(negedge clk);
        check("R10 eob one cycle", 32'(eob), 0);
        req_pulse(2'b01); @(negedge clk);
        check("R10 disarmed after eob", 32'(gnt), 0);

        // R11: compare end of block with interrupt disabled
        load(1'b1, 16'd1);
        req_pulse(2'b10); @(negedge clk);
        done_pulse();
        check("R10 eob compare", 32'(eob), 2);
        check("R11 irq masked", 32'(eob_irq), 0);

        // R9: zero load leaves channel disarmed
        load(1'b1, 16'd0);
        req_pulse(2'b10); @(negedge clk);
        check("R9 zero load no grant", 32'(gnt), 0);
        load(1'b1, 16'd3);
        req_pulse(2'b10); @(negedge clk);
        check("R9 nonzero load arms", 32'(gnt), 2);
        done_pulse();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule